// File: doc/BRIEF.md
# Reset Source Capture Register

This block sits beside the reset generator of a small controller. It watches four reset sources: a power-on-clear pulse, the external reset pin, a reset request from the watchdog and a reset request from the low-voltage detector. From them it forms one combined system reset, which stays asserted while any source is active and for a fixed stretch of cycles after the last one goes away.

The block also keeps a sticky record of which internal source caused the reset. The two flag flip-flops are cleared only by power-on-clear or the external pin. The system reset they help to produce never clears them, so the record survives the reset it caused. After restart, software reads one status byte through a plain 8-bit read port. A read of the register returns its contents and then clears it.

Top module: `rstcap_unit`

## Requirements
- R1: The cycle after power-on-clear ends, a read of the status register returns 0x00.
- R2: In the status byte, bit 4 is the watchdog flag and bit 0 is the low-voltage flag. Bits 1, 2, 3, 5, 6 and 7 always read 0.
- R3: A cycle with the external reset pin high leaves both flags at 0 in the next cycle.
- R4: A cycle with power-on-clear high leaves both flags at 0 in the next cycle.
- R5: A watchdog request sets the watchdog flag to 1 and leaves the low-voltage flag unchanged.
- R6: A low-voltage request sets the low-voltage flag to 1 and leaves the watchdog flag unchanged.
- R7: A read with the strobe high and address 0xFFAC returns the current flags in that same cycle. The flags are 0 from the next cycle on.
- R8: Watchdog and low-voltage requests in the same cycle set both flags.
- R9: If a set request and a clearing read fall in the same cycle, the flag is 1 afterwards.
- R10: The read data is 0x00 whenever the strobe is low or the address is not 0xFFAC. Such a cycle does not clear the flags.
- R11: The system reset output is high in every cycle in which any of the four sources is high.
- R12: After the last source goes low, the system reset stays high for exactly HOLD_CYCLES further cycles (default 16) and then goes low.
- R13: The flags keep their values while the system reset is asserted and after it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| power_on_clr | input | 1 | Power-on-clear pulse, active high |
| pin_rst | input | 1 | External reset pin, active high |
| wdog_req | input | 1 | Watchdog reset request, active high |
| lowv_req | input | 1 | Low-voltage reset request, active high |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 16 | Read byte address |
| bus_rdata | output | 8 | Read data, 0 when the register is not being read |
| sys_rst | output | 1 | Combined, stretched system reset |

## Verification
The hardest cases to reach from the ports are two. The first is a read of the register in the very cycle in which a new request arrives. The second is a flag that must survive while its own system reset is still asserted. The stimulus lines up the read strobe with the cycle of a watchdog request, and it reads the register both during the reset stretch and after it. A cycle-accurate model in the bench shows whether the set won and whether the flag outlived the stretch.

// File: rtl/rstcap_pkg.sv
package rstcap_pkg;

    localparam int NUM_INT   = 2;
    localparam int STATUS_W  = 8;
    localparam int IDX_LOWV  = 0;
    localparam int IDX_WDOG  = 1;

    typedef struct packed {
        logic por;
        logic pin;
        logic wdog;
        logic lowv;
    } src_bundle_t;

    typedef logic [NUM_INT-1:0] flag_vec_t;

    function automatic int flag_bit_pos(input int idx);
        return (idx == IDX_WDOG) ? 4 : 0;
    endfunction

    function automatic logic [STATUS_W-1:0] pack_status(input flag_vec_t f);
        logic [STATUS_W-1:0] s;
        s = '0;
        for (int i = 0; i < NUM_INT; i++) begin
            s[flag_bit_pos(i)] = f[i];
        end
        return s;
    endfunction

    function automatic logic any_source(input src_bundle_t s);
        return s.por | s.pin | s.wdog | s.lowv;
    endfunction

endpackage

// File: rtl/rstcap_stretch.sv
module rstcap_stretch #(
    parameter int HOLD_CYCLES = 16
) (
    input  logic clk,
    input  logic power_on_clr,
    input  logic src_any,
    output logic sys_rst
);
    localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

    logic [CNT_W-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (src_any) begin
            hold_cnt <= CNT_W'(HOLD_CYCLES);
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign sys_rst = src_any | (hold_cnt != '0);

    // R12: reset still asserted one cycle after any source
    p_hold_after_src_r12: assert property (@(posedge clk) disable iff (power_on_clr)
        src_any |=> sys_rst);

    // R12: reset follows the sources once the stretch has run out
    p_release_r12: assert property (@(posedge clk) disable iff (power_on_clr)
        (!src_any && hold_cnt == CNT_W'(1)) |=> (sys_rst == src_any));

endmodule

// File: rtl/rstcap_flags.sv
module rstcap_flags
    import rstcap_pkg::*;
(
    input  logic      clk,
    input  logic      dom_rst,
    input  flag_vec_t set_req,
    input  logic      rd_clr,
    output flag_vec_t flags
);
    flag_vec_t flag_q;

    for (genvar i = 0; i < NUM_INT; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (dom_rst) begin
                flag_q[i] <= 1'b0;
            end else if (set_req[i]) begin
                flag_q[i] <= 1'b1;
            end else if (rd_clr) begin
                flag_q[i] <= 1'b0;
            end
        end

        // R9: a set beats a clearing read in the same cycle
        p_set_wins_r9: assert property (@(posedge clk) disable iff (dom_rst)
            set_req[i] |=> flag_q[i]);

        // R7: a clearing read with no set empties the flag
        p_read_clear_r7: assert property (@(posedge clk) disable iff (dom_rst)
            (rd_clr && !set_req[i]) |=> !flag_q[i]);

        // R13: with no set and no read the flag is held
        p_sticky_r13: assert property (@(posedge clk) disable iff (dom_rst)
            (!set_req[i] && !rd_clr) |=> (flag_q[i] == $past(flag_q[i])));
    end

    assign flags = flag_q;

endmodule

// File: rtl/rstcap_rdport.sv
module rstcap_rdport
    import rstcap_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFFAC
) (
    input  logic                clk,
    input  logic                dom_rst,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  flag_vec_t           flags,
    output logic [STATUS_W-1:0] bus_rdata,
    output logic                rd_clr
);
    localparam logic [STATUS_W-1:0] USED_MASK = pack_status('1);

    logic hit;

    always_comb begin
        hit       = bus_rd && (bus_addr == REG_ADDR);
        bus_rdata = hit ? pack_status(flags) : '0;
        rd_clr    = hit;
    end

    // R10: bus idle or wrong address gives zero data
    p_idle_zero_r10: assert property (@(posedge clk) disable iff (dom_rst)
        !(bus_rd && bus_addr == REG_ADDR) |-> (bus_rdata == '0));

    // R2: unused bit positions never read as 1
    p_unused_bits_r2: assert property (@(posedge clk) disable iff (dom_rst)
        ((bus_rdata & ~USED_MASK) == '0));

endmodule

// File: rtl/rstcap_unit.sv
module rstcap_unit
    import rstcap_pkg::*;
#(
    parameter int              ADDR_W      = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 16'hFFAC,
    parameter int              HOLD_CYCLES = 16
) (
    input  logic                clk,
    input  logic                power_on_clr,
    input  logic                pin_rst,
    input  logic                wdog_req,
    input  logic                lowv_req,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic [STATUS_W-1:0] bus_rdata,
    output logic                sys_rst
);
    src_bundle_t src;
    flag_vec_t   set_req;
    flag_vec_t   flags;
    logic        dom_rst;
    logic        rd_clr;

    always_comb begin
        src.por  = power_on_clr;
        src.pin  = pin_rst;
        src.wdog = wdog_req;
        src.lowv = lowv_req;
        dom_rst  = src.por | src.pin;
        set_req  = '0;
        set_req[IDX_WDOG] = src.wdog;
        set_req[IDX_LOWV] = src.lowv;
    end

    rstcap_stretch #(.HOLD_CYCLES(HOLD_CYCLES)) u_stretch (
        .clk          (clk),
        .power_on_clr (power_on_clr),
        .src_any      (any_source(src)),
        .sys_rst      (sys_rst)
    );

    rstcap_flags u_flags (
        .clk     (clk),
        .dom_rst (dom_rst),
        .set_req (set_req),
        .rd_clr  (rd_clr),
        .flags   (flags)
    );

    rstcap_rdport #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_rdport (
        .clk       (clk),
        .dom_rst   (dom_rst),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .flags     (flags),
        .bus_rdata (bus_rdata),
        .rd_clr    (rd_clr)
    );

    // R3: external pin empties both flags
    p_pin_clears_r3: assert property (@(posedge clk) disable iff (power_on_clr)
        pin_rst |=> (flags == '0));

    // R4: power-on-clear empties both flags
    p_por_clears_r4: assert property (@(posedge clk) disable iff (pin_rst)
        power_on_clr |=> (flags == '0));

    // R11: any active source drives the system reset
    p_src_asserts_r11: assert property (@(posedge clk) disable iff (power_on_clr)
        (pin_rst || wdog_req || lowv_req) |-> sys_rst);

    // R5: watchdog request leaves the low-voltage flag alone
    p_wdog_keeps_lowv_r5: assert property (@(posedge clk) disable iff (dom_rst)
        (wdog_req && !lowv_req && !rd_clr) |=> (flags[IDX_LOWV] == $past(flags[IDX_LOWV])));

    // R6: low-voltage request leaves the watchdog flag alone
    p_lowv_keeps_wdog_r6: assert property (@(posedge clk) disable iff (dom_rst)
        (lowv_req && !wdog_req && !rd_clr) |=> (flags[IDX_WDOG] == $past(flags[IDX_WDOG])));

endmodule

// File: tb/rstcap_unit_test.sv
`timescale 1ns/1ps
module rstcap_unit_test;
    localparam int HOLD = 16;
    localparam logic [15:0] REG = 16'hFFAC;

    logic        clk = 1'b0;
    logic        power_on_clr = 1'b1;
    logic        pin_rst = 1'b0;
    logic        wdog_req = 1'b0;
    logic        lowv_req = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_rdata;
    logic        sys_rst;

    int checks = 0;
    int errors = 0;
    bit model_on = 1'b0;

    // behavioural reference
    int m_wdog = 0;
    int m_lowv = 0;
    int m_cnt  = 0;

    always #2.5 clk = ~clk;

    rstcap_unit #(.HOLD_CYCLES(HOLD)) uut (
        .clk(clk), .power_on_clr(power_on_clr), .pin_rst(pin_rst),
        .wdog_req(wdog_req), .lowv_req(lowv_req), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_rdata(bus_rdata), .sys_rst(sys_rst)
    );

    function automatic bit is_hit();
        return bus_rd && bus_addr == REG;
    endfunction

    always @(posedge clk) begin
        bit any;
        any = power_on_clr || pin_rst || wdog_req || lowv_req;
        if (power_on_clr || pin_rst) begin
            m_wdog = 0;
            m_lowv = 0;
        end else begin
            if (wdog_req) m_wdog = 1; else if (is_hit()) m_wdog = 0;
            if (lowv_req) m_lowv = 1; else if (is_hit()) m_lowv = 0;
        end
        if (any) m_cnt = HOLD;
        else if (m_cnt > 0) m_cnt = m_cnt - 1;
        model_on = 1'b1;
    end

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // compare outputs against the model, then advance one clock
    task automatic cyc(input string tag);
        logic [7:0] exp_rd;
        bit exp_rst;
        #1;
        if (model_on) begin
            exp_rd = is_hit() ? 8'((m_wdog << 4) | m_lowv) : 8'h00;
            exp_rst = power_on_clr || pin_rst || wdog_req || lowv_req || (m_cnt > 0);
            check8({tag, " rdata"}, bus_rdata, exp_rd);
            check8({tag, " sys_rst"}, {7'd0, sys_rst}, {7'd0, exp_rst});
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    // one read cycle; returns the data seen
    task automatic rd(input logic [15:0] a, input string tag, output logic [7:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1; d = bus_rdata;
        cyc(tag);
        bus_rd = 1'b0; bus_addr = 16'h0000;
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int stretch;
        @(negedge clk);
        cyc("R4 por"); cyc("R4 por");
        power_on_clr = 1'b0;
        idle(HOLD + 2, "R12 por stretch");
        check8("R12 low after por stretch", {7'd0, sys_rst}, 8'h00);
        rd(REG, "R1 reset read", d);
        check8("R1 status after power-on", d, 8'h00);

        // watchdog reset, stretch length, sticky through reset
        wdog_req = 1'b1;
        cyc("R11 wdog"); cyc("R11 wdog");
        wdog_req = 1'b0;
        stretch = 0;
        for (int i = 0; i < HOLD + 6; i++) begin
            #1; if (sys_rst) stretch++;
            cyc("R12 wdog stretch");
        end
        check8("R12 stretch length", 8'(stretch), 8'(HOLD));
        rd(REG, "R5 read", d);
        check8("R5 R13 wdog flag kept", d, 8'h10);
        rd(REG, "R7 reread", d);
        check8("R7 cleared by read", d, 8'h00);

        // wdog then lowv: wdog flag kept
        wdog_req = 1'b1; cyc("R5 wdog"); wdog_req = 1'b0;
        idle(3, "R13 during stretch");
        rd(REG, "R13 read in stretch", d);
        check8("R13 flag during sys_rst", d, 8'h10);
        wdog_req = 1'b1; cyc("R5 wdog"); wdog_req = 1'b0;
        lowv_req = 1'b1; cyc("R6 lowv"); lowv_req = 1'b0;
        idle(HOLD + 2, "R6 stretch");
        rd(16'hFFAD, "R10 wrong addr", d);
        check8("R10 wrong address data", d, 8'h00);
        bus_rd = 1'b0; bus_addr = REG; #1;
        check8("R10 strobe low data", bus_rdata, 8'h00);
        cyc("R10 strobe low");
        rd(REG, "R6 read", d);
        check8("R6 R2 both flags", d, 8'h11);

        // lowv alone keeps cleared wdog flag
        lowv_req = 1'b1; cyc("R6 lowv"); lowv_req = 1'b0;
        idle(HOLD + 2, "R6 stretch");
        rd(REG, "R6 lowv only", d);
        check8("R6 lowv only", d, 8'h01);

        // simultaneous
        wdog_req = 1'b1; lowv_req = 1'b1; cyc("R8 both");
        wdog_req = 1'b0; lowv_req = 1'b0;
        idle(HOLD + 2, "R8 stretch");
        rd(REG, "R8 read", d);
        check8("R8 both set", d, 8'h11);

        // set and clearing read in the same cycle
        wdog_req = 1'b1;
        rd(REG, "R9 collide", d);
        check8("R9 read sees old contents", d, 8'h00);
        wdog_req = 1'b0;
        idle(HOLD + 2, "R9 stretch");
        rd(REG, "R9 read", d);
        check8("R9 set wins", d, 8'h10);

        // external pin clears
        wdog_req = 1'b1; lowv_req = 1'b1; cyc("R3 set"); wdog_req = 1'b0; lowv_req = 1'b0;
        pin_rst = 1'b1; cyc("R3 pin"); pin_rst = 1'b0;
        idle(HOLD + 2, "R3 stretch");
        rd(REG, "R3 read", d);
        check8("R3 pin cleared", d, 8'h00);

        // power-on-clear clears
        lowv_req = 1'b1; cyc("R4 set"); lowv_req = 1'b0;
        power_on_clr = 1'b1; cyc("R4 por"); power_on_clr = 1'b0;
        idle(HOLD + 2, "R4 stretch");
        rd(REG, "R4 read", d);
        check8("R4 por cleared", d, 8'h00);
        check8("R12 idle low", {7'd0, sys_rst}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule